// File: doc/BRIEF.md
# Polled Console Device Controller

This block lets a processor drive a character console with ordinary loads and stores. It occupies a sixteen-byte window at a fixed base address and presents four 32-bit word registers. Two belong to the input side and two to the output side. Each side has a status/control word and a character word. There is no storage behind the window. A load from the input character word takes a character from the keyboard side. A store to the output character word hands a character to the display side.

The registers do more than hold values. Reading the input character withdraws the input side's ready flag. Writing the output character drops the output side's ready flag until the display has been busy for a fixed number of cycles. Software can therefore poll a ready bit and then move one byte. If software sets a per-side enable bit, it can instead wait on a level interrupt output.

A character source pushes bytes with a one-cycle valid strobe. The block presents each outgoing byte to the display sink as a one-cycle strobe. Reads are combinational from the current state. Every side effect of an access takes place at the clock edge that ends the access cycle.

Top module: `mmio_console`

## Requirements
- R1: After reset, the input status word reads 0x00000000, the output status word reads 0x00000001, irq is 0 and disp_valid is 0.
- R2: An access hits only when address bits 31:4 equal those of BASE (default 0xFFFF0000). Word select uses address bits 3:2: 0 is input status, 1 is input character, 2 is output status, 3 is output character. Address bits 1:0 are ignored. A load that misses the window, and any store, returns bus_rdata 0. An access that misses has no effect on any state.
- R3: A key_valid strobe stores key_byte and sets bit 0 (ready) of the input status word from the next cycle on.
- R4: A load from the input character word returns the stored byte in bits 7:0 with bits 31:8 zero. When no character arrives in the same cycle, the load clears input ready and the overrun bit from the next cycle.
- R5: A character that arrives while input ready is 1 replaces the stored byte and sets overrun (input status bit 2). A data read in that same cycle returns the older byte and leaves ready at 1 with overrun at 0.
- R6: A store to either status word changes only bit 1 (interrupt enable), which takes wdata bit 1. Ready and overrun are not writable. A read returns the enable in bit 1, and bits above those defined read 0.
- R7: A store to the output character word while output ready is 1 pulses disp_valid for exactly the next cycle, with disp_byte equal to wdata bits 7:0. Output ready then reads 0 for TX_BUSY cycles and 1 again afterwards.
- R8: A store to the output character word while output ready is 0 produces no disp_valid pulse and does not lengthen the busy time.
- R9: irq is high exactly while (input ready and input enable) or (output ready and output enable).
- R10: A load from the output character word returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access in this cycle |
| bus_we | input | 1 | 1 store, 0 load |
| bus_addr | input | 32 | Byte address of the access |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Load data (combinational) |
| key_valid | input | 1 | Incoming character strobe |
| key_byte | input | 8 | Incoming character |
| disp_valid | output | 1 | Outgoing character strobe |
| disp_byte | output | 8 | Outgoing character |
| irq | output | 1 | Level interrupt request |

## Verification
The in-RTL assertions check the edge-local rules on every cycle. These are: an arrival raises ready, a lone data read lowers ready and overrun, an arrival on a full register raises overrun, an accepted store starts a display pulse and drops ready, a store during busy produces no pulse, and ready returns only when the busy count is spent. Other properties need a reference model running over whole sequences. These include the exact busy length, zero-extension and address aliasing, the same-cycle read-and-arrival case, the absence of side effects from accesses outside the window, and the interrupt level across enable changes. The bench's model follows each of these over directed and pseudo-random traffic.

// File: rtl/mmio_console_pkg.sv
// Shared definitions for the polled console controller.
// Assumes 32-bit word registers laid out on 4-byte boundaries.
package mmio_console_pkg;
    typedef enum logic [1:0] {
        REG_RX_CTL = 2'd0,
        REG_RX_DAT = 2'd1,
        REG_TX_CTL = 2'd2,
        REG_TX_DAT = 2'd3
    } con_reg_e;

    localparam int NUM_REGS = 4;
    localparam int RDY_BIT  = 0;
    localparam int IE_BIT   = 1;
    localparam int OVR_BIT  = 2;
endpackage

// File: rtl/con_bus_decode.sv
// Address decode for the console window: produces one load strobe and one
// store strobe per register. Assumes word-aligned registers and that the
// window is aligned to its own size.
module con_bus_decode
    import mmio_console_pkg::*;
#(
    parameter int          ADDR_W = 32,
    parameter logic [31:0] BASE   = 32'hFFFF_0000
) (
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              hit,
    output con_reg_e          which,
    output logic [NUM_REGS-1:0] rd_stb,
    output logic [NUM_REGS-1:0] wr_stb
);
    localparam int SEL_W   = $clog2(NUM_REGS);
    localparam int WIN_LSB = SEL_W + 2;

    logic [ADDR_W-1:0] base_w;
    logic              unused_addr_bits;

    assign base_w           = ADDR_W'(BASE);
    assign unused_addr_bits = ^bus_addr[1:0];

    // window match and register index
    always_comb begin
        hit   = bus_sel && (bus_addr[ADDR_W-1:WIN_LSB] == base_w[ADDR_W-1:WIN_LSB]);
        which = con_reg_e'(bus_addr[WIN_LSB-1:2]);
    end

    // one strobe per register, per direction
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_stb
        assign rd_stb[g] = hit && !bus_we && (which == con_reg_e'(g));
        assign wr_stb[g] = hit &&  bus_we && (which == con_reg_e'(g));
    end
endmodule

// File: rtl/con_rx_unit.sv
// Receive side: holds the last incoming character, its ready flag, the
// overrun flag and the interrupt enable. An arrival wins over a same-cycle
// read; the read then still counts as consuming the older byte.
module con_rx_unit #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [CHAR_W-1:0] key_byte,
    input  logic              rd_data,
    input  logic              wr_ctl,
    input  logic              ie_wr,
    output logic              ready,
    output logic              ovr,
    output logic              ie,
    output logic [CHAR_W-1:0] data
);
    // character, ready and overrun update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready <= 1'b0;
            ovr   <= 1'b0;
            data  <= '0;
        end else if (key_valid) begin
            data  <= key_byte;
            ready <= 1'b1;
            ovr   <= ready && !rd_data;
        end else if (rd_data) begin
            ready <= 1'b0;
            ovr   <= 1'b0;
        end
    end

    // interrupt enable written by a store to the status word
    always_ff @(posedge clk) begin
        if (!rst_n)      ie <= 1'b0;
        else if (wr_ctl) ie <= ie_wr;
    end

    // R3
    key_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> ready);
    // R4
    read_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data && !key_valid |=> !ready && !ovr);
    // R5
    overrun_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid && ready && !rd_data |=> ovr);
endmodule

// File: rtl/con_tx_unit.sv
// Transmit side: accepts one character when ready, emits it as a one-cycle
// strobe and stays busy for TX_BUSY cycles. Stores made while busy are dropped.
module con_tx_unit #(
    parameter int CHAR_W  = 8,
    parameter int TX_BUSY = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_data,
    input  logic [CHAR_W-1:0] wchar,
    input  logic              wr_ctl,
    input  logic              ie_wr,
    output logic              ready,
    output logic              ie,
    output logic              disp_valid,
    output logic [CHAR_W-1:0] disp_byte
);
    localparam int CNT_W = (TX_BUSY > 1) ? $clog2(TX_BUSY) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(TX_BUSY - 1);

    logic [CNT_W-1:0] cnt;
    logic             accept;

    assign accept = wr_data && ready;

    // busy counter and ready flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready <= 1'b1;
            cnt   <= '0;
        end else if (accept) begin
            ready <= 1'b0;
            cnt   <= CNT_LOAD;
        end else if (!ready) begin
            if (cnt == '0) ready <= 1'b1;
            else           cnt   <= cnt - 1'b1;
        end
    end

    // outgoing character strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_valid <= 1'b0;
            disp_byte  <= '0;
        end else begin
            disp_valid <= accept;
            if (accept) disp_byte <= wchar;
        end
    end

    // interrupt enable written by a store to the status word
    always_ff @(posedge clk) begin
        if (!rst_n)      ie <= 1'b0;
        else if (wr_ctl) ie <= ie_wr;
    end

    // R7
    send_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data && ready |=> disp_valid && !ready);
    // R8
    busy_store_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data && !ready |=> !disp_valid);
    // R7
    ready_after_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(cnt) == '0);
endmodule

// File: rtl/mmio_console.sv
// Top of the polled console controller: decode, receive and transmit sides,
// read multiplexer and interrupt. Reads are combinational; side effects
// land on the clock edge ending the access cycle.
module mmio_console
    import mmio_console_pkg::*;
#(
    parameter int          ADDR_W  = 32,
    parameter int          DATA_W  = 32,
    parameter int          CHAR_W  = 8,
    parameter logic [31:0] BASE    = 32'hFFFF_0000,
    parameter int          TX_BUSY = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              key_valid,
    input  logic [CHAR_W-1:0] key_byte,
    output logic              disp_valid,
    output logic [CHAR_W-1:0] disp_byte,
    output logic              irq
);
    logic                hit;
    con_reg_e            which;
    logic [NUM_REGS-1:0] rd_stb, wr_stb;
    logic                rx_rdy, rx_ovr, rx_ie, tx_rdy, tx_ie;
    logic [CHAR_W-1:0]   rx_data;
    logic                unused_wdata;

    assign unused_wdata = ^{bus_wdata[DATA_W-1:CHAR_W], bus_wdata[0]};

    con_bus_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .hit(hit), .which(which), .rd_stb(rd_stb), .wr_stb(wr_stb)
    );

    con_rx_unit #(.CHAR_W(CHAR_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .key_valid(key_valid), .key_byte(key_byte),
        .rd_data(rd_stb[REG_RX_DAT]), .wr_ctl(wr_stb[REG_RX_CTL]),
        .ie_wr(bus_wdata[IE_BIT]),
        .ready(rx_rdy), .ovr(rx_ovr), .ie(rx_ie), .data(rx_data)
    );

    con_tx_unit #(.CHAR_W(CHAR_W), .TX_BUSY(TX_BUSY)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .wr_data(wr_stb[REG_TX_DAT]), .wchar(bus_wdata[CHAR_W-1:0]),
        .wr_ctl(wr_stb[REG_TX_CTL]), .ie_wr(bus_wdata[IE_BIT]),
        .ready(tx_rdy), .ie(tx_ie),
        .disp_valid(disp_valid), .disp_byte(disp_byte)
    );

    // read multiplexer, zero outside the window and on stores
    always_comb begin
        bus_rdata = '0;
        if (hit && !bus_we) begin
            unique case (which)
                REG_RX_CTL: begin
                    bus_rdata[RDY_BIT] = rx_rdy;
                    bus_rdata[IE_BIT]  = rx_ie;
                    bus_rdata[OVR_BIT] = rx_ovr;
                end
                REG_RX_DAT: bus_rdata[CHAR_W-1:0] = rx_data;
                REG_TX_CTL: begin
                    bus_rdata[RDY_BIT] = tx_rdy;
                    bus_rdata[IE_BIT]  = tx_ie;
                end
                REG_TX_DAT: bus_rdata = '0;
            endcase
        end
    end

    // level interrupt from both sides
    assign irq = (rx_rdy && rx_ie) || (tx_rdy && tx_ie);

    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rx_rdy || tx_rdy));
    // R2
    miss_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit && !key_valid && tx_rdy |=> $stable(rx_rdy) && $stable(rx_data) && !disp_valid);
endmodule

// File: tb/mmio_console_test.sv
`timescale 1ns/1ps
module mmio_console_test;
    localparam int BUSY = 6;
    localparam logic [31:0] B = 32'hFFFF_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0, key_valid = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic [7:0]  key_byte = '0;
    logic [31:0] bus_rdata;
    logic        disp_valid, irq;
    logic [7:0]  disp_byte;

    int checks = 0, bad = 0;

    // reference state
    int m_rxr, m_ovr, m_rxie, m_rxd, m_txr, m_txie, m_cnt, m_dv, m_db;

    always #2.5 clk = ~clk;

    mmio_console #(.TX_BUSY(BUSY)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .key_valid(key_valid), .key_byte(key_byte),
        .disp_valid(disp_valid), .disp_byte(disp_byte), .irq(irq)
    );

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_rxr = 0; m_ovr = 0; m_rxie = 0; m_rxd = 0;
        m_txr = 1; m_txie = 0; m_cnt = 0; m_dv = 0; m_db = 0;
    endtask

    // one bus cycle: drive, compare against the model, then advance the model
    task automatic cyc(input logic s, input logic w, input logic [31:0] a,
                       input logic [31:0] wd, input logic kv,
                       input logic [7:0] kb, input string tag);
        logic        hit;
        int          off;
        logic [31:0] exp;
        string       t;
        @(negedge clk);
        bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = wd;
        key_valid = kv; key_byte = kb;
        #1;
        hit = s && (a[31:4] == B[31:4]);
        off = int'(a[3:2]);
        exp = 0;
        t = tag;
        if (!hit)      begin if (t == "") t = "R2"; end
        else if (off == 0) begin if (t == "") t = "R3";
                                 exp = m_rxr + 2*m_rxie + 4*m_ovr; end
        else if (off == 1) begin if (t == "") t = "R4"; exp = m_rxd; end
        else if (off == 2) begin if (t == "") t = "R7";
                                 exp = m_txr + 2*m_txie; end
        else if (t == "") t = "R10";
        if (w) exp = 0;
        check(bus_rdata === exp, t, "rdata", bus_rdata, exp);
        check(irq === ((m_rxr && m_rxie) || (m_txr && m_txie)), "R9", "irq",
              32'(irq), 32'((m_rxr && m_rxie) || (m_txr && m_txie)));
        check(disp_valid === m_dv[0], (m_dv != 0) ? "R7" : "R8", "disp_valid",
              32'(disp_valid), 32'(m_dv));
        if (m_dv != 0)
            check(disp_byte === 8'(m_db), "R7", "disp_byte", 32'(disp_byte), 32'(m_db));
        @(posedge clk);
        // receive side
        if (kv) begin
            m_ovr = (m_rxr != 0 && !(hit && !w && off == 1)) ? 1 : 0;
            m_rxd = kb; m_rxr = 1;
        end else if (hit && !w && off == 1) begin
            m_rxr = 0; m_ovr = 0;
        end
        if (hit && w && off == 0) m_rxie = wd[1];
        // transmit side
        m_dv = 0;
        if (hit && w && off == 3 && m_txr != 0) begin
            m_dv = 1; m_db = wd[7:0]; m_txr = 0; m_cnt = BUSY - 1;
        end else if (m_txr == 0) begin
            if (m_cnt == 0) m_txr = 1; else m_cnt--;
        end
        if (hit && w && off == 2) m_txie = wd[1];
    endtask

    task automatic rd(input logic [31:0] a, input string tag);
        cyc(1, 0, a, 0, 0, 0, tag);
    endtask
    task automatic wr(input logic [31:0] a, input logic [31:0] d, input string tag);
        cyc(1, 1, a, d, 0, 0, tag);
    endtask
    task automatic key(input logic [7:0] b, input string tag);
        cyc(0, 0, 0, 0, 1, b, tag);
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, "");
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(B + 0, "R1"); rd(B + 8, "R1"); rd(B + 4, "R1");

        // R3 / R4: arrival, read, zero extension, ready clears
        key(8'h41, "R3"); rd(B + 0, "R3"); rd(B + 4, "R4"); rd(B + 0, "R4");
        key(8'hFE, "R3"); rd(B + 7, "R2"); rd(B + 0, "R4");

        // R5: overrun, then same-cycle read and arrival
        key(8'h10, "R5"); key(8'h20, "R5"); rd(B + 0, "R5"); rd(B + 4, "R5");
        rd(B + 0, "R5");
        key(8'h30, "R5"); key(8'h31, "R5");
        cyc(1, 0, B + 4, 0, 1, 8'h32, "R5");
        rd(B + 0, "R5"); rd(B + 4, "R5");

        // R6: status stores touch only the enable
        key(8'h55, "R6"); wr(B + 0, 32'hFFFF_FFFF, "R6"); rd(B + 0, "R6");
        wr(B + 0, 32'h0000_0005, "R6"); rd(B + 0, "R6");
        wr(B + 8, 32'hFFFF_FFFE, "R6"); rd(B + 8, "R6");

        // R9: interrupt from each side
        wr(B + 0, 2, "R9"); idle(2); rd(B + 4, "R9"); idle(1);
        wr(B + 8, 2, "R9"); idle(1);

        // R7 / R8: send, store while busy, poll until ready
        wr(B + 12, 32'h1234_56C3, "R7"); rd(B + 8, "R7");
        wr(B + 12, 32'h0000_0055, "R8");
        for (int i = 0; i < BUSY + 2; i++) rd(B + 8, "R7");
        wr(B + 12, 32'h0000_007A, "R7"); idle(BUSY + 1);
        wr(B + 8, 0, "R9");

        // R10 and R2: write-only word, misses outside the window
        rd(B + 12, "R10");
        key(8'h66, "R2"); rd(32'hFFFE_0004, "R2"); rd(B + 16 + 4, "R2");
        wr(32'hFFFF_001C, 32'h99, "R2"); rd(B + 0, "R2"); rd(B + 4, "R2");

        // mixed pseudo-random traffic
        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(lfsr[0], lfsr[1],
                (lfsr[9:8] == 2'b11 && lfsr[10]) ? 32'hFFFF_0020 : B + {lfsr[4:2], 2'b00},
                {24'h0, lfsr[15:8]}, lfsr[6] & lfsr[7], lfsr[11:4], "");
        end

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule